// File: doc/BRIEF.md
# Requestor Miss Completion Tracker

This block sits beside a processor in a directory-coherent multiprocessor node and follows each coherence transaction that processor has in flight, up to four at a time. It records the line and request kind on issue, sends the request to the network, and gathers whatever comes back: the reply from the home, a speculative copy of the data, the owner's data or bare acknowledgement, and every invalidation acknowledgement promised by the home. The processor sees one completion per transaction, and only once every piece has arrived.

The tracker also settles incoming traffic for lines it owns. A negative acknowledgement puts the transaction into a short pseudo-random wait before it is sent again; a refused upgrade is resent as a read-exclusive. A forwarded intervention to a line whose operation is still open is parked and released together with that operation's completion. One that meets a pending writeback is thrown away. Interventions to lines not being tracked pass straight through to the local cache.

Top module: `mct_tracker`

## Requirements
- R1: Out of reset no transaction is open: `req_ready` is 1 and `cpl_valid`, `nout_valid` and `ivo_valid` are 0.
- R2: At most four transactions are open at once; with four open and no completion in progress, `req_ready` is 0 for any line.
- R3: A request whose line equals that of an open transaction is held off (`req_ready` 0) while a slot is free; a request to another line is accepted.
- R4: Each accepted request goes out once on the network port with its own line and kind, kinds coded 0 read, 1 read-exclusive, 2 upgrade, 3 writeback.
- R5: A home reply (message type 0) carries data and an ack count; the completion is given only after that many invalidation acks (type 4) have arrived, counting acks that came before the reply, and it carries the home reply's data.
- R6: After a speculative reply (type 1), the completion needs an owner response: owner data (type 2) replaces the speculative data, an owner ack (type 3) keeps it; this holds in either arrival order.
- R7: An intervention (type 7) to an open non-writeback line produces nothing until that line completes; it then appears on `ivo_valid`/`ivo_addr` on the same edge as the completion.
- R8: An intervention to a line with an open writeback never appears on the intervention output; the writeback completes when a writeback ack (type 5 is NACK, type 6 is writeback ack) arrives.
- R9: On a NACK (type 5) the transaction is resent between 2 and 17 edges after the edge that takes the NACK, and a refused upgrade is resent with kind 1.
- R10: An intervention to a line not being tracked appears on the intervention output on the edge that takes it.
- R11: Every transaction completes exactly once, and its slot is then free for a new request to the same line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Processor presents a request |
| req_ready | output | 1 | Request accepted this cycle |
| req_kind | input | 2 | Request kind (0 read, 1 read-exclusive, 2 upgrade, 3 writeback) |
| req_addr | input | ADDR_W | Line address of the request |
| cpl_valid | output | 1 | One-cycle completion to the processor |
| cpl_addr | output | ADDR_W | Line of the completed transaction |
| cpl_data | output | DATA_W | Data delivered with the completion |
| nout_valid | output | 1 | Request leaving for the network |
| nout_kind | output | 2 | Kind of the outgoing request |
| nout_addr | output | ADDR_W | Line of the outgoing request |
| nin_valid | input | 1 | Incoming network message |
| nin_type | input | 3 | Message type, coded as in R5 to R10 |
| nin_addr | input | ADDR_W | Line the message refers to |
| nin_data | input | DATA_W | Data carried by the message |
| nin_acks | input | ACK_W | Invalidation ack count on a home or speculative reply |
| ivo_valid | output | 1 | Intervention handed to the local cache |
| ivo_addr | output | ADDR_W | Line of that intervention |

## Verification
The reply collection is swept over every ack count from zero to three combined with every number of acks arriving ahead of the home reply, which separates a counter that tolerates early acks from one that wraps or completes early. The speculative path is tried with owner data and owner ack, each in both orders, telling an overriding owner response from a stale one. Interventions are sent to a collecting write, a writeback and an untracked line, distinguishing hold, drop and pass-through, and repeated NACKs on upgrades and read-exclusives measure the resend window and the kind change.

// File: rtl/mct_pkg.sv
package mct_pkg;
  typedef enum logic [1:0] {
    RQ_READ  = 2'd0,
    RQ_RDEX  = 2'd1,
    RQ_UPGR  = 2'd2,
    RQ_WBACK = 2'd3
  } rq_kind_e;

  typedef enum logic [2:0] {
    MS_HOME   = 3'd0,
    MS_SPEC   = 3'd1,
    MS_ODATA  = 3'd2,
    MS_OACK   = 3'd3,
    MS_INVACK = 3'd4,
    MS_NACK   = 3'd5,
    MS_WBDONE = 3'd6,
    MS_INTV   = 3'd7
  } ms_kind_e;

  typedef enum logic [1:0] {
    SL_IDLE,
    SL_SEND,
    SL_WAIT,
    SL_BACK
  } sl_state_e;
endpackage

// File: rtl/mct_pick.sv
module mct_pick #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/mct_lfsr.sv
module mct_lfsr #(
  parameter int          OUT_W = 4,
  parameter logic [7:0]  SEED  = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd
);
  logic [7:0] sr_q, sr_d;

  always_comb begin
    sr_d = {1'b0, sr_q[7:1]} ^ (sr_q[0] ? 8'hB8 : 8'h00);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= SEED;
    else        sr_q <= sr_d;
  end

  assign rnd = sr_q[OUT_W-1:0];
endmodule

// File: rtl/mct_slot.sv
module mct_slot
  import mct_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int ACK_W  = 4,
  parameter int BO_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic [1:0]        alloc_kind,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              msg_hit,
  input  logic [2:0]        msg_type,
  input  logic [DATA_W-1:0] msg_data,
  input  logic [ACK_W-1:0]  msg_acks,
  input  logic              iv_hold,
  input  logic [BO_W-1:0]   bo_seed,
  input  logic              send_gnt,
  input  logic              retire,
  output logic              busy,
  output logic              want_send,
  output logic              done,
  output logic              iv_pend,
  output logic              is_wb,
  output logic [1:0]        kind,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  sl_state_e               st_q, st_d;
  logic [1:0]              kind_q, kind_d;
  logic [ADDR_W-1:0]       addr_q, addr_d;
  logic [DATA_W-1:0]       data_q, data_d;
  logic signed [ACK_W:0]   cnt_q, cnt_d;
  logic                    home_q, home_d, spec_q, spec_d;
  logic                    own_q, own_d, odat_q, odat_d, iv_q, iv_d;
  logic [BO_W:0]           bo_q, bo_d;
  logic                    upd;

  assign upd = alloc | msg_hit | iv_hold | send_gnt | retire | (st_q == SL_BACK);

  always_comb begin
    st_d = st_q;   kind_d = kind_q; addr_d = addr_q; data_d = data_q;
    cnt_d = cnt_q; home_d = home_q; spec_d = spec_q; own_d = own_q;
    odat_d = odat_q; iv_d = iv_q;  bo_d = bo_q;
    if (alloc) begin
      st_d = SL_SEND; kind_d = alloc_kind; addr_d = alloc_addr; data_d = '0;
      cnt_d = '0; home_d = 1'b0; spec_d = 1'b0; own_d = 1'b0; odat_d = 1'b0;
      iv_d = 1'b0; bo_d = '0;
    end else begin
      if (retire) begin
        st_d = SL_IDLE;
        iv_d = 1'b0;
      end
      if (send_gnt) st_d = SL_WAIT;
      if (st_q == SL_BACK) begin
        bo_d = bo_q - (BO_W+1)'(1);
        if (bo_q == (BO_W+1)'(1)) st_d = SL_SEND;
      end
      if (iv_hold) iv_d = 1'b1;
      if (msg_hit) begin
        case (ms_kind_e'(msg_type))
          MS_HOME: begin
            home_d = 1'b1;
            data_d = msg_data;
            cnt_d  = cnt_q + $signed({1'b0, msg_acks});
          end
          MS_SPEC: begin
            spec_d = 1'b1;
            if (!odat_q) data_d = msg_data;
            cnt_d  = cnt_q + $signed({1'b0, msg_acks});
          end
          MS_ODATA: begin
            own_d = 1'b1; odat_d = 1'b1; data_d = msg_data;
          end
          MS_OACK:   own_d = 1'b1;
          MS_INVACK: cnt_d = cnt_q - (ACK_W+1)'(1);
          MS_NACK: begin
            st_d = SL_BACK;
            bo_d = {1'b0, bo_seed} + (BO_W+1)'(1);
            if (kind_q == RQ_UPGR) kind_d = RQ_RDEX;
            cnt_d = '0; home_d = 1'b0; spec_d = 1'b0; own_d = 1'b0; odat_d = 1'b0;
          end
          MS_WBDONE: home_d = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SL_IDLE; kind_q <= '0; addr_q <= '0; data_q <= '0; cnt_q <= '0;
      home_q <= 1'b0; spec_q <= 1'b0; own_q <= 1'b0; odat_q <= 1'b0;
      iv_q <= 1'b0; bo_q <= '0;
    end else if (upd) begin
      st_q <= st_d; kind_q <= kind_d; addr_q <= addr_d; data_q <= data_d;
      cnt_q <= cnt_d; home_q <= home_d; spec_q <= spec_d; own_q <= own_d;
      odat_q <= odat_d; iv_q <= iv_d; bo_q <= bo_d;
    end
  end

  assign busy      = (st_q != SL_IDLE);
  assign want_send = (st_q == SL_SEND);
  assign done      = (st_q == SL_WAIT) && (home_q || (spec_q && own_q)) && (cnt_q == '0);
  assign iv_pend   = iv_q;
  assign is_wb     = (kind_q == RQ_WBACK);
  assign kind      = kind_q;
  assign addr      = addr_q;
  assign data      = data_q;
endmodule

// File: rtl/mct_tracker.sv
module mct_tracker
  import mct_pkg::*;
#(
  parameter int NSLOT  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int ACK_W  = 4,
  parameter int BO_W   = 4,
  localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              cpl_valid,
  output logic [ADDR_W-1:0] cpl_addr,
  output logic [DATA_W-1:0] cpl_data,
  output logic              nout_valid,
  output logic [1:0]        nout_kind,
  output logic [ADDR_W-1:0] nout_addr,
  input  logic              nin_valid,
  input  logic [2:0]        nin_type,
  input  logic [ADDR_W-1:0] nin_addr,
  input  logic [DATA_W-1:0] nin_data,
  input  logic [ACK_W-1:0]  nin_acks,
  output logic              ivo_valid,
  output logic [ADDR_W-1:0] ivo_addr
);
  logic [NSLOT-1:0]             s_busy, s_want, s_done, s_ivp, s_wb;
  logic [NSLOT-1:0][1:0]        s_kind;
  logic [NSLOT-1:0][ADDR_W-1:0] s_addr;
  logic [NSLOT-1:0][DATA_W-1:0] s_data;
  logic [NSLOT-1:0]             req_hit, nin_hit, msg_hit, iv_hold, ret_req;
  logic [NSLOT-1:0]             alloc_g, send_g, ret_g;
  logic                         f_any, sd_any, rt_any, accept, is_intv, pass_iv;
  logic [SW-1:0]                f_idx, sd_idx, rt_idx;
  logic [BO_W-1:0]              bo_rnd;

  logic              cplv_d, noutv_d, ivov_d;
  logic [ADDR_W-1:0] ivoa_d;

  assign is_intv   = nin_valid && (nin_type == MS_INTV);
  assign pass_iv   = is_intv && (nin_hit == '0);
  assign req_ready = f_any && (req_hit == '0);
  assign accept    = req_valid && req_ready;

  mct_pick #(.N(NSLOT)) u_pick_free (.req(~s_busy), .any(f_any),  .idx(f_idx));
  mct_pick #(.N(NSLOT)) u_pick_send (.req(s_want),  .any(sd_any), .idx(sd_idx));
  mct_pick #(.N(NSLOT)) u_pick_ret  (.req(ret_req), .any(rt_any), .idx(rt_idx));
  mct_lfsr #(.OUT_W(BO_W)) u_lfsr (.clk(clk), .rst_n(rst_n), .rnd(bo_rnd));

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign req_hit[g] = s_busy[g] && (s_addr[g] == req_addr);
    assign nin_hit[g] = s_busy[g] && (s_addr[g] == nin_addr);
    assign msg_hit[g] = nin_valid && !is_intv && nin_hit[g];
    assign iv_hold[g] = is_intv && nin_hit[g] && !s_wb[g];
    assign ret_req[g] = s_done[g] && !iv_hold[g] && !(pass_iv && s_ivp[g]);
    assign alloc_g[g] = accept && (f_idx == SW'(g));
    assign send_g[g]  = sd_any && (sd_idx == SW'(g));
    assign ret_g[g]   = rt_any && (rt_idx == SW'(g));

    mct_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACK_W(ACK_W), .BO_W(BO_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .alloc(alloc_g[g]), .alloc_kind(req_kind), .alloc_addr(req_addr),
      .msg_hit(msg_hit[g]), .msg_type(nin_type), .msg_data(nin_data), .msg_acks(nin_acks),
      .iv_hold(iv_hold[g]), .bo_seed(bo_rnd), .send_gnt(send_g[g]), .retire(ret_g[g]),
      .busy(s_busy[g]), .want_send(s_want[g]), .done(s_done[g]), .iv_pend(s_ivp[g]),
      .is_wb(s_wb[g]), .kind(s_kind[g]), .addr(s_addr[g]), .data(s_data[g])
    );
  end

  always_comb begin
    cplv_d  = rt_any;
    noutv_d = sd_any;
    ivov_d  = pass_iv || (rt_any && s_ivp[rt_idx]);
    ivoa_d  = pass_iv ? nin_addr : s_addr[rt_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpl_valid <= 1'b0; nout_valid <= 1'b0; ivo_valid <= 1'b0;
      cpl_addr <= '0; cpl_data <= '0; nout_kind <= '0; nout_addr <= '0; ivo_addr <= '0;
    end else begin
      cpl_valid  <= cplv_d;
      nout_valid <= noutv_d;
      ivo_valid  <= ivov_d;
      if (cplv_d) begin
        cpl_addr <= s_addr[rt_idx];
        cpl_data <= s_data[rt_idx];
      end
      if (noutv_d) begin
        nout_kind <= s_kind[sd_idx];
        nout_addr <= s_addr[sd_idx];
      end
      if (ivov_d) ivo_addr <= ivoa_d;
    end
  end
endmodule

// File: rtl/mct_tracker_chk.sv
module mct_tracker_chk #(
  parameter int NSLOT  = 4,
  parameter int ADDR_W = 16,
  localparam int CW    = $clog2(NSLOT + 1) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              cpl_valid,
  input logic              nin_valid,
  input logic [2:0]        nin_type,
  input logic [ADDR_W-1:0] nin_addr,
  input logic              ivo_valid,
  input logic [ADDR_W-1:0] ivo_addr,
  input logic [NSLOT-1:0]  nin_hit,
  input logic [NSLOT-1:0]  s_wb
);
  logic [CW-1:0] open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= '0;
    else open_q <= open_q + CW'(req_valid && req_ready) - CW'(cpl_valid);
  end

  AST_SLOT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    open_q <= CW'(NSLOT)); // R2
  AST_READY_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q == CW'(NSLOT) && !cpl_valid) |-> !req_ready); // R2
  AST_UNIQUE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(nin_hit)); // R3
  AST_PASS_INTERV: assert property (@(posedge clk) disable iff (!rst_n)
    (nin_valid && nin_type == 3'd7 && nin_hit == '0) |=> (ivo_valid && ivo_addr == $past(nin_addr))); // R10
  AST_WB_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (nin_valid && nin_type == 3'd7 && (nin_hit & s_wb) != '0) |=> !(ivo_valid && ivo_addr == $past(nin_addr))); // R8
endmodule

bind mct_tracker mct_tracker_chk #(.NSLOT(NSLOT), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .cpl_valid(cpl_valid), .nin_valid(nin_valid), .nin_type(nin_type), .nin_addr(nin_addr),
  .ivo_valid(ivo_valid), .ivo_addr(ivo_addr), .nin_hit(nin_hit), .s_wb(s_wb)
);

// File: tb/mct_tracker_tb.sv
`timescale 1ns/1ps
module mct_tracker_tb_top;
  logic        clk, rst_n;
  logic        req_valid, req_ready;
  logic [1:0]  req_kind;
  logic [15:0] req_addr;
  logic        cpl_valid;
  logic [15:0] cpl_addr;
  logic [31:0] cpl_data;
  logic        nout_valid;
  logic [1:0]  nout_kind;
  logic [15:0] nout_addr;
  logic        nin_valid;
  logic [2:0]  nin_type;
  logic [15:0] nin_addr;
  logic [31:0] nin_data;
  logic [3:0]  nin_acks;
  logic        ivo_valid;
  logic [15:0] ivo_addr;

  mct_tracker dut_i (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, msg_edge = 0;
  int n_cpl = 0, n_nout = 0, n_ivo = 0;
  int l_cpl_cyc = 0, l_nout_cyc = 0, l_ivo_cyc = 0;
  logic [15:0] l_cpl_addr, l_nout_addr, l_ivo_addr;
  logic [31:0] l_cpl_data;
  logic [1:0]  l_nout_kind;
  bit done_flag = 0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    #1;
    if (cpl_valid)  begin n_cpl++;  l_cpl_cyc = cyc;  l_cpl_addr = cpl_addr; l_cpl_data = cpl_data; end
    if (nout_valid) begin n_nout++; l_nout_cyc = cyc; l_nout_addr = nout_addr; l_nout_kind = nout_kind; end
    if (ivo_valid)  begin n_ivo++;  l_ivo_cyc = cyc;  l_ivo_addr = ivo_addr; end
  end

  task automatic check(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic req(logic [1:0] k, logic [15:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic msg(logic [2:0] t, logic [15:0] a, logic [31:0] d, logic [3:0] n);
    @(negedge clk);
    nin_valid = 1'b1; nin_type = t; nin_addr = a; nin_data = d; nin_acks = n;
    msg_edge = cyc + 1;
    @(negedge clk);
    nin_valid = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      report();
    end
  end

  initial begin
    int b_cpl, b_nout, b_ivo;
    logic [15:0] a;
    req_valid = 0; req_kind = 0; req_addr = 0;
    nin_valid = 0; nin_type = 0; nin_addr = 0; nin_data = 0; nin_acks = 0;
    rst_n = 0;
    idle(3);
    #1;
    check("R1 ready", req_ready, 1);
    check("R1 cpl", cpl_valid, 0);
    check("R1 nout", nout_valid, 0);
    check("R1 ivo", ivo_valid, 0);
    @(negedge clk); rst_n = 1;
    idle(2);

    // R5 sweep: ack count n, e of them ahead of the home reply
    for (int n = 0; n <= 3; n++) begin
      for (int e = 0; e <= n; e++) begin
        a = 16'h0100 + 16'(n * 16 + e);
        b_nout = n_nout; b_cpl = n_cpl;
        req((n == 0) ? 2'd0 : 2'd1, a);
        idle(3);
        check("R4 issue count", n_nout, b_nout + 1);
        check("R4 issue addr", l_nout_addr, a);
        check("R4 issue kind", l_nout_kind, (n == 0) ? 0 : 1);
        for (int k = 0; k < e; k++) msg(3'd4, a, 0, 0);
        idle(3);
        check("R5 early", n_cpl, b_cpl);
        msg(3'd0, a, 32'hD000_0000 + a, 4'(n));
        for (int k = e; k < n; k++) begin
          idle(3);
          check("R5 waiting acks", n_cpl, b_cpl);
          msg(3'd4, a, 0, 0);
        end
        idle(3);
        check("R5 complete", n_cpl, b_cpl + 1);
        check("R5 addr", l_cpl_addr, a);
        check("R5 data", l_cpl_data, 32'hD000_0000 + a);
        idle(3);
        check("R11 single", n_cpl, b_cpl + 1);
      end
    end

    // R6 speculative paths
    for (int v = 0; v < 4; v++) begin
      a = 16'h0200 + 16'(v);
      b_cpl = n_cpl;
      req(2'd1, a); idle(3);
      if (v[0]) begin
        msg((v < 2) ? 3'd2 : 3'd3, a, 32'hBEEF_0000 + a, 0);
        msg(3'd1, a, 32'h5BEC_0000 + a, 0);
      end else begin
        msg(3'd1, a, 32'h5BEC_0000 + a, 0);
        idle(3);
        check("R6 needs owner", n_cpl, b_cpl);
        msg((v < 2) ? 3'd2 : 3'd3, a, 32'hBEEF_0000 + a, 0);
      end
      idle(3);
      check("R6 complete", n_cpl, b_cpl + 1);
      check("R6 data", l_cpl_data, (v < 2) ? 32'hBEEF_0000 + a : 32'h5BEC_0000 + a);
    end

    // R2, R3, R11 occupancy
    for (int i = 0; i < 4; i++) req(2'd0, 16'h0300 + 16'(i));
    idle(3);
    req_addr = 16'h0399; #1;
    check("R2 full", req_ready, 0);
    msg(3'd0, 16'h0300, 32'h1, 0);
    idle(3);
    req_addr = 16'h0300; #1;
    check("R11 reuse", req_ready, 1);
    req_addr = 16'h0301; #1;
    check("R3 same line", req_ready, 0);
    req_addr = 16'h0399; #1;
    check("R3 other line", req_ready, 1);
    for (int i = 1; i < 4; i++) msg(3'd0, 16'h0300 + 16'(i), 32'h2, 0);
    idle(4);

    // R7 deferred intervention
    a = 16'h0400; b_cpl = n_cpl; b_ivo = n_ivo;
    req(2'd1, a); idle(3);
    msg(3'd0, a, 32'h7, 4'd2);
    msg(3'd7, a, 0, 0);
    idle(3);
    check("R7 held", n_ivo, b_ivo);
    msg(3'd4, a, 0, 0); idle(3);
    check("R7 held cpl", n_cpl, b_cpl);
    msg(3'd4, a, 0, 0); idle(3);
    check("R7 release", n_ivo, b_ivo + 1);
    check("R7 release addr", l_ivo_addr, a);
    check("R7 same edge", l_ivo_cyc, l_cpl_cyc);

    // R8 writeback crossing
    a = 16'h0500; b_cpl = n_cpl; b_ivo = n_ivo;
    req(2'd3, a); idle(3);
    msg(3'd7, a, 0, 0); idle(3);
    check("R8 dropped", n_ivo, b_ivo);
    check("R8 open", n_cpl, b_cpl);
    msg(3'd6, a, 0, 0); idle(3);
    check("R8 wb done", n_cpl, b_cpl + 1);
    check("R8 wb addr", l_cpl_addr, a);
    check("R8 still dropped", n_ivo, b_ivo);

    // R10 untracked pass-through
    b_ivo = n_ivo;
    msg(3'd7, 16'h0600, 0, 0); idle(2);
    check("R10 passed", n_ivo, b_ivo + 1);
    check("R10 addr", l_ivo_addr, 16'h0600);
    check("R10 edge", l_ivo_cyc - msg_edge, 0);

    // R9 NACK backoff
    for (int t = 0; t < 6; t++) begin
      int dly;
      a = 16'h0700;
      req(t[0] ? 2'd1 : 2'd2, a); idle(3);
      b_nout = n_nout;
      msg(3'd5, a, 0, 0);
      idle(22);
      dly = l_nout_cyc - msg_edge;
      check("R9 resent", n_nout, b_nout + 1);
      check("R9 window", int'(dly >= 2 && dly <= 17), 1);
      check("R9 kind", l_nout_kind, 1);
      msg(3'd0, a, 0, 0); idle(3);
    end

    done_flag = 1;
    report();
  end
endmodule